// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Unit

A memory-mapped timer peripheral holding three reloadable down-counters and one wide free-running up-counter, reached through a single-cycle register bus (word address, write data, write strobe, combinational read data). Two of the down-counters are 16 bits wide and the third is 32 bits wide. Each one counts on either a fast or a slow tick-enable input, picked per channel. When it passes zero it raises its own interrupt line, which stays high until software writes to that channel's clear register.

Each down-counter runs in one of two modes. In periodic mode it refills from its load register on underflow, so a load of N gives a period of N+1 ticks. In free mode it wraps to all-ones. The fourth channel is a 40-bit timestamp that advances on its own tick input and never interrupts. It is switched on and off through a flag in its upper-word register, and switching it off returns it to zero. The tick inputs are one-cycle enables made elsewhere in the chip.

Top module: `mc_tick_timer`

## Requirements
- R1: After reset, every count, load value, control field, interrupt line and the timestamp (count and enable flag) are zero.
- R2: A write to a down-channel's load register stores the value and copies it into the count in the same clock edge. Reading the value register returns the live count, and reading the load register returns the stored load value.
- R3: Control register fields: bit 7 enables counting, bit 6 selects periodic mode, bit 3 selects the count source (1 = fastTick, 0 = slowTick). The register reads back with only these bits possibly set. An enabled channel drops by one on each cycle its selected tick is high. A disabled channel, or one whose selected tick is low, holds its count.
- R4: In periodic mode a tick at count zero reloads the load value, so a load value of N gives an underflow every N+1 ticks.
- R5: In free mode a tick at count zero wraps the count to the channel's all-ones value.
- R6: Every underflow sets the channel's interrupt bit (irqOut bit 0/1/2 for channels 1/2/3), which stays set until a write of any data to that channel's clear register. If an underflow and a clear write land in the same cycle, the interrupt stays set.
- R7: Channels 1 and 2 are 16 bits wide and channel 3 is 32 bits wide. Load writes keep only the channel's low bits, and reads return zero above the channel width.
- R8: Word addresses: channel 1 block at 0x00, channel 2 at 0x20, channel 3 at 0x80. Within a block, load is +0x0, value +0x4, control +0x8 and clear +0xC. The timestamp low word is at 0x60 and its high word at 0x64. Unmapped or misaligned addresses read zero, and writes to them change nothing.
- R9: A write to the timestamp high word with data bit 8 set enables the timestamp. It then rises by one on each cycle stampTick is high, and it ignores fastTick and slowTick. It never drives irqOut.
- R10: A timestamp low-word read returns count bits 31:0. A high-word read returns count bits 39:32 in bits 7:0 and the enable flag in bit 8. A high-word write with bit 8 clear disables the timestamp and zeroes it. Writes to the low word have no effect.
- R11: When a load write and a selected tick land in the same cycle, the count takes the written value and no underflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRdata | output | 32 | Read data for busAddr, combinational |
| fastTick | input | 1 | Fast count enable for down channels |
| slowTick | input | 1 | Slow count enable for down channels |
| stampTick | input | 1 | Count enable for the timestamp |
| irqOut | output | 3 | Per-channel underflow interrupts |

## Verification
The bench targets the exact underflow tick. A design that reloads one tick early or late gives a period of N or N+2, and reads back a count one away from the expected one. It drives a clear write together with an underflowing tick: a design that lets the clear win loses the interrupt. It also drives a load write together with a tick: a design that lets the tick win shows the written value minus one. The remaining checks cover the narrow-channel wrap to 0xFFFF rather than a 32-bit value, a disabled or wrongly sourced channel that still counts, the timestamp failing to return to zero when disabled, and low-word writes that are not ignored.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_DOWN = 3;
  localparam int CHAN_IDX_W = $clog2(NUM_DOWN);

  // block base addresses, upper nibble of the byte address
  localparam logic [3:0] CHAN_BLOCK [NUM_DOWN] = '{4'h0, 4'h2, 4'h8};
  localparam logic [3:0] STAMP_BLOCK = 4'h6;

  // word index within a block
  localparam logic [1:0] REG_LOAD  = 2'd0;
  localparam logic [1:0] REG_VALUE = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;
  localparam logic [1:0] REG_CLEAR = 2'd3;
  localparam logic [1:0] REG_STAMP_LO = 2'd0;
  localparam logic [1:0] REG_STAMP_HI = 2'd1;

  // control field positions
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FAST_BIT = 3;

  typedef struct packed {
    logic [NUM_DOWN-1:0] loadWr;
    logic [NUM_DOWN-1:0] ctrlWr;
    logic [NUM_DOWN-1:0] clrWr;
    logic                stampHiWr;
  } mctStrobes_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LOAD,
    RD_VALUE,
    RD_CTRL,
    RD_STAMP_LO,
    RD_STAMP_HI
  } mctRdKind_t;
endpackage

// File: rtl/mct_ctrl.sv
module mct_ctrl
  import mct_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  output mctStrobes_t           strobes,
  output mctRdKind_t            rdKind,
  output logic [CHAN_IDX_W-1:0] rdChan
);
  logic [3:0] blockSel;
  logic [1:0] wordSel;
  logic       aligned;

  assign blockSel = busAddr[7:4];
  assign wordSel  = busAddr[3:2];
  assign aligned  = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    rdKind  = RD_NONE;
    rdChan  = '0;
    if (aligned) begin
      for (int i = 0; i < NUM_DOWN; i++) begin
        if (blockSel == CHAN_BLOCK[i]) begin
          rdChan = CHAN_IDX_W'(i);
          unique case (wordSel)
            REG_LOAD: begin
              rdKind = RD_LOAD;
              strobes.loadWr[i] = busWe;
            end
            REG_VALUE: rdKind = RD_VALUE;
            REG_CTRL: begin
              rdKind = RD_CTRL;
              strobes.ctrlWr[i] = busWe;
            end
            default: strobes.clrWr[i] = busWe;
          endcase
        end
      end
      if (blockSel == STAMP_BLOCK) begin
        if (wordSel == REG_STAMP_LO) begin
          rdKind = RD_STAMP_LO;
        end else if (wordSel == REG_STAMP_HI) begin
          rdKind = RD_STAMP_HI;
          strobes.stampHiWr = busWe;
        end
      end
    end
  end

  // R8: a single bus write never strikes two registers
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadWr, strobes.ctrlWr, strobes.clrWr, strobes.stampHiWr}));

  // R8: misaligned accesses decode to nothing
  a_r8_misaligned_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00) |-> (strobes == '0 && rdKind == RD_NONE));
endmodule

// File: rtl/mct_down_chan.sv
module mct_down_chan
  import mct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadWr,
  input  logic             ctrlWr,
  input  logic             clrWr,
  input  logic [W-1:0]     loadData,
  input  logic             enIn,
  input  logic             perIn,
  input  logic             fastIn,
  input  logic             fastTick,
  input  logic             slowTick,
  output logic [BUS_W-1:0] countWord,
  output logic [BUS_W-1:0] loadWord,
  output logic [BUS_W-1:0] ctrlWord,
  output logic             irq
);
  logic [W-1:0] count;
  logic [W-1:0] loadVal;
  logic         ctrlEn, ctrlPer, ctrlFast;
  logic         tickHit, atZero, underflow;

  assign tickHit   = ctrlEn & (ctrlFast ? fastTick : slowTick);
  assign atZero    = (count == '0);
  assign underflow = tickHit & atZero & ~loadWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      loadVal  <= '0;
      ctrlEn   <= 1'b0;
      ctrlPer  <= 1'b0;
      ctrlFast <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctrlEn   <= enIn;
        ctrlPer  <= perIn;
        ctrlFast <= fastIn;
      end
      if (loadWr) begin
        loadVal <= loadData;
        count   <= loadData;
      end else if (tickHit) begin
        if (atZero) count <= ctrlPer ? loadVal : '1;
        else        count <= count - W'(1);
      end
      if (underflow)  irq <= 1'b1;
      else if (clrWr) irq <= 1'b0;
    end
  end

  assign countWord = BUS_W'(count);
  assign loadWord  = BUS_W'(loadVal);

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CTRL_EN_BIT]   = ctrlEn;
    ctrlWord[CTRL_PER_BIT]  = ctrlPer;
    ctrlWord[CTRL_FAST_BIT] = ctrlFast;
  end

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (tickHit && !atZero && !loadWr) |=> count == $past(count) - W'(1));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!tickHit && !loadWr) |=> $stable(count));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && ctrlPer) |=> count == $past(loadVal));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !ctrlPer) |=> (&count));

  a_r6_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> irq);

  a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !underflow) |=> !irq);

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrWr) |=> irq);

  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> count == $past(loadData));
endmodule

// File: rtl/mct_datapath.sv
module mct_datapath
  import mct_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int STAMP_W  = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mctStrobes_t           strobes,
  input  mctRdKind_t            rdKind,
  input  logic [CHAN_IDX_W-1:0] rdChan,
  input  logic [BUS_W-1:0]      busWdata,
  input  logic                  fastTick,
  input  logic                  slowTick,
  input  logic                  stampTick,
  output logic [BUS_W-1:0]      busRdata,
  output logic [NUM_DOWN-1:0]   irqOut
);
  localparam int STAMP_HI_W = STAMP_W - BUS_W;
  localparam int STAMP_EN_BIT = STAMP_HI_W;

  logic [BUS_W-1:0] countWord [NUM_DOWN];
  logic [BUS_W-1:0] loadWord  [NUM_DOWN];
  logic [BUS_W-1:0] ctrlWord  [NUM_DOWN];

  for (genvar g = 0; g < NUM_DOWN; g++) begin : g_chan
    localparam int CW = (g == NUM_DOWN - 1) ? WIDE_W : NARROW_W;
    mct_down_chan #(.W(CW)) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .loadWr    (strobes.loadWr[g]),
      .ctrlWr    (strobes.ctrlWr[g]),
      .clrWr     (strobes.clrWr[g]),
      .loadData  (busWdata[CW-1:0]),
      .enIn      (busWdata[CTRL_EN_BIT]),
      .perIn     (busWdata[CTRL_PER_BIT]),
      .fastIn    (busWdata[CTRL_FAST_BIT]),
      .fastTick  (fastTick),
      .slowTick  (slowTick),
      .countWord (countWord[g]),
      .loadWord  (loadWord[g]),
      .ctrlWord  (ctrlWord[g]),
      .irq       (irqOut[g])
    );
  end

  // free-running timestamp
  logic [STAMP_W-1:0] stampCnt;
  logic               stampEn;
  logic               stampOff;

  assign stampOff = strobes.stampHiWr & ~busWdata[STAMP_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stampCnt <= '0;
      stampEn  <= 1'b0;
    end else begin
      if (strobes.stampHiWr) stampEn <= busWdata[STAMP_EN_BIT];
      if (stampOff)                   stampCnt <= '0;
      else if (stampEn && stampTick)  stampCnt <= stampCnt + STAMP_W'(1);
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (rdKind)
      RD_LOAD:     if (int'(rdChan) < NUM_DOWN) busRdata = loadWord[rdChan];
      RD_VALUE:    if (int'(rdChan) < NUM_DOWN) busRdata = countWord[rdChan];
      RD_CTRL:     if (int'(rdChan) < NUM_DOWN) busRdata = ctrlWord[rdChan];
      RD_STAMP_LO: busRdata = stampCnt[BUS_W-1:0];
      RD_STAMP_HI: busRdata = BUS_W'({stampEn, stampCnt[STAMP_W-1:BUS_W]});
      default:     busRdata = '0;
    endcase
  end

  a_r9_stamp_step: assert property (@(posedge clk) disable iff (!rstN)
    (stampEn && stampTick && !stampOff) |=> stampCnt == $past(stampCnt) + STAMP_W'(1));

  a_r9_stamp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(stampEn && stampTick) && !stampOff) |=> $stable(stampCnt));

  a_r10_stamp_off_zero: assert property (@(posedge clk) disable iff (!rstN)
    stampOff |=> (stampCnt == '0 && !stampEn));
endmodule

// File: rtl/mc_tick_timer.sv
module mc_tick_timer
  import mct_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int STAMP_W  = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWdata,
  input  logic                busWe,
  output logic [BUS_W-1:0]    busRdata,
  input  logic                fastTick,
  input  logic                slowTick,
  input  logic                stampTick,
  output logic [NUM_DOWN-1:0] irqOut
);
  mctStrobes_t           strobes;
  mctRdKind_t            rdKind;
  logic [CHAN_IDX_W-1:0] rdChan;

  mct_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes),
    .rdKind  (rdKind),
    .rdChan  (rdChan)
  );

  mct_datapath #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .STAMP_W  (STAMP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rdKind    (rdKind),
    .rdChan    (rdChan),
    .busWdata  (busWdata),
    .fastTick  (fastTick),
    .slowTick  (slowTick),
    .stampTick (stampTick),
    .busRdata  (busRdata),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/mc_tick_timer_tb.sv
module mc_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic        busWe;
  logic [31:0] busRdata;
  logic        fastTick, slowTick, stampTick;
  logic [2:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_tick_timer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .fastTick(fastTick),
    .slowTick(slowTick), .stampTick(stampTick), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit withFast = 1'b0);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; fastTick = withFast;
    @(negedge clk);
    busWe = 1'b0; fastTick = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 check(req, busRdata, exp);
  endtask

  task automatic irqCheck(input string req, input logic [2:0] exp);
    @(negedge clk);
    #1 check(req, {29'b0, irqOut}, {29'b0, exp});
  endtask

  // which: 0 fast, 1 slow, 2 stamp
  task automatic pulse(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      fastTick = (which == 0); slowTick = (which == 1); stampTick = (which == 2);
      @(negedge clk);
      fastTick = 1'b0; slowTick = 1'b0; stampTick = 1'b0;
    end
  endtask

  task automatic t_reset;
    rdCheck("R1 ch1 value", 8'h04, 0);
    rdCheck("R1 ch2 load", 8'h20, 0);
    rdCheck("R1 ch3 ctrl", 8'h88, 0);
    rdCheck("R1 stamp hi", 8'h64, 0);
    rdCheck("R1 stamp lo", 8'h60, 0);
    irqCheck("R1 irq", 3'b000);
  endtask

  task automatic t_periodic;
    wr(8'h00, 5);
    rdCheck("R2 value after load", 8'h04, 5);
    rdCheck("R2 load readback", 8'h00, 5);
    wr(8'h08, 32'hFFFF_FFC8);
    rdCheck("R3 ctrl readback", 8'h08, 32'hC8);
    pulse(0, 3);
    rdCheck("R3 fast count", 8'h04, 2);
    pulse(1, 2);
    rdCheck("R3 slow ignored when fast selected", 8'h04, 2);
    pulse(0, 2);
    rdCheck("R4 reached zero", 8'h04, 0);
    irqCheck("R6 no irq before underflow", 3'b000);
    pulse(0, 1);
    rdCheck("R4 reload on sixth tick", 8'h04, 5);
    irqCheck("R6 irq on underflow", 3'b001);
    pulse(0, 2);
    irqCheck("R6 irq held", 3'b001);
    wr(8'h0C, 0);
    irqCheck("R6 irq cleared", 3'b000);
  endtask

  task automatic t_freerun;
    wr(8'h20, 1);
    wr(8'h28, 32'h80);
    pulse(0, 2);
    rdCheck("R3 fast ignored when slow selected", 8'h24, 1);
    pulse(1, 2);
    rdCheck("R5 narrow wrap", 8'h24, 32'hFFFF);
    irqCheck("R6 ch2 irq", 3'b010);
    wr(8'h2C, 32'hDEAD);
    irqCheck("R6 ch2 clear any data", 3'b000);
  endtask

  task automatic t_wide;
    wr(8'h80, 32'h1234_5678);
    rdCheck("R7 wide load", 8'h84, 32'h1234_5678);
    wr(8'h88, 32'hC0);
    wr(8'h80, 2);
    pulse(1, 3);
    rdCheck("R4 wide reload", 8'h84, 2);
    irqCheck("R6 ch3 irq", 3'b100);
    wr(8'h8C, 1);
    wr(8'h88, 32'h88);
    wr(8'h80, 0);
    pulse(0, 1);
    rdCheck("R5 wide wrap", 8'h84, 32'hFFFF_FFFF);
    wr(8'h8C, 0);
    wr(8'h88, 0);
    irqCheck("R6 ch3 cleared", 3'b000);
  endtask

  task automatic t_truncate;
    wr(8'h00, 32'hABCD_1234);
    rdCheck("R7 narrow truncation", 8'h04, 32'h1234);
  endtask

  task automatic t_load_race;
    wr(8'h00, 7, 1'b1);
    rdCheck("R11 load beats tick", 8'h04, 7);
    irqCheck("R11 no underflow", 3'b000);
    pulse(0, 1);
    rdCheck("R3 count after race", 8'h04, 6);
  endtask

  task automatic t_clear_race;
    wr(8'h00, 0);
    wr(8'h0C, 0, 1'b1);
    irqCheck("R6 underflow beats clear", 3'b001);
    wr(8'h0C, 0);
    irqCheck("R6 clear afterwards", 3'b000);
  endtask

  task automatic t_disabled;
    wr(8'h08, 32'h48);
    wr(8'h00, 9);
    pulse(0, 3);
    rdCheck("R3 disabled holds", 8'h04, 9);
  endtask

  task automatic t_map;
    rdCheck("R8 unmapped reads zero", 8'h40, 0);
    rdCheck("R8 misaligned reads zero", 8'h25, 0);
    wr(8'h44, 32'h55);
    wr(8'h21, 32'h77);
    rdCheck("R8 stray writes ignored", 8'h20, 1);
  endtask

  task automatic t_stamp;
    wr(8'h64, 32'h100);
    pulse(2, 5);
    rdCheck("R9 stamp counts", 8'h60, 5);
    rdCheck("R10 stamp high word", 8'h64, 32'h100);
    wr(8'h60, 32'hFFFF);
    rdCheck("R10 low write ignored", 8'h60, 5);
    pulse(0, 2);
    pulse(1, 2);
    rdCheck("R9 other ticks ignored", 8'h60, 5);
    irqCheck("R9 no irq from stamp", 3'b000);
    wr(8'h64, 0);
    rdCheck("R10 disable zeroes low", 8'h60, 0);
    rdCheck("R10 disable clears flag", 8'h64, 0);
    pulse(2, 2);
    rdCheck("R10 disabled stays zero", 8'h60, 0);
  endtask

  initial begin
    rstN = 1'b0; busAddr = '0; busWdata = '0; busWe = 1'b0;
    fastTick = 1'b0; slowTick = 1'b0; stampTick = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_periodic();
    t_freerun();
    t_wide();
    t_truncate();
    t_load_race();
    t_clear_race();
    t_disabled();
    t_map();
    t_stamp();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule